// File: doc/BRIEF.md
# USB On-The-Go B-Device Role Controller

This block is the hardware state machine for the dual-role B-device side of USB On-The-Go. It reads status conditions from the rest of the port: ID pin level, B-session valid, B-session end, SE0 long enough for a session request, local bus request, HNP enable, A-device connect, A-bus suspend and A-bus resume. From these it drives the local pull-up connect, VBUS charging, local SOF generation and the VBUS drive line. It runs the session request pulse sequence and the HNP role swap to host and back without software stepping each transition.

There are five states. `ST_IDLE` (code 0) is entered from reset. `ST_SRP` (code 1) plays the session request pulses. `ST_PERIPH` (code 2) is the normal peripheral role. `ST_WAITA` (code 3) waits for the A-device to connect after an HNP request. `ST_HOST` (code 4) is the swapped host role. The transitions are as follows. Idle goes to SRP on a session request, or to peripheral when the session becomes valid. SRP returns to idle when the pulses are done or when ID goes low. Peripheral goes to wait-for-connect on an HNP request. Wait-for-connect goes to host when the A-device connects. It returns to peripheral on resume or on a timeout. Host falls back to peripheral when the request or the connection drops. Peripheral, wait-for-connect and host all go to idle when ID goes low or the session ends.

A single prescaler turns the clock into 10 µs ticks, `TICK_DIV` clocks apart. The session request pulse windows and the wait-for-connect timeout are counted in these ticks. The current state is reported as a 3-bit code.

Top module: `otgb_role_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the state code is 0 (idle) and `loc_conn`, `chrg_vbus`, `loc_sof` and `drv_vbus` are all low.
- R2: From idle with `id_hi` high and `b_sess_vld` low, the state moves to 1 (SRP) on the clock edge after `bus_req`, `b_sess_end` and `se0_srp` are all high. If `b_sess_vld` is high at that edge, the state goes to 2 (peripheral) instead.
- R3: In SRP, `loc_conn` is high for the first `PU_TICKS` ticks. Then `chrg_vbus` is high for the next `CHG_TICKS` ticks. Then the state returns to idle on the next edge.
- R4: In SRP, `id_hi` low returns the state to idle on the next edge and ends both pulses.
- R5: From idle with `id_hi` high, `b_sess_vld` high moves the state to 2 (peripheral). In peripheral, `loc_conn` is high, and `loc_sof` and `chrg_vbus` are low. With `id_hi` low the state stays idle.
- R6: From peripheral, `bus_req`, `hnp_en` and `a_bus_suspend` all high move the state to 3 (wait-for-connect). In that state all outputs are low.
- R7: A tick counter starts at zero on entry to wait-for-connect. When the count reaches `acon_limit`, the state returns to peripheral. A limit of 0 returns on the first edge. `a_bus_resume` also returns the state to peripheral.
- R8: In wait-for-connect, `a_conn` moves the state to 4 (host), ahead of resume and timeout. In host, `loc_sof` is high and `loc_conn` is low.
- R9: In host, `bus_req` low or `a_conn` low returns the state to peripheral.
- R10: From peripheral, wait-for-connect or host, `id_hi` low or `b_sess_vld` low returns the state to idle on the next edge, ahead of every other transition.
- R11: `drv_vbus` is low in every state.
- R12: `state_o` uses the codes idle=0, SRP=1, peripheral=2, wait-for-connect=3, host=4.
- R13: Ticks occur once every `TICK_DIV` clocks, the first one `TICK_DIV` clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_hi | input | 1 | ID pin high (B-device side) |
| b_sess_vld | input | 1 | B-session valid |
| b_sess_end | input | 1 | B-session end |
| se0_srp | input | 1 | SE0 held long enough for a session request |
| bus_req | input | 1 | Local software requests the bus |
| hnp_en | input | 1 | HNP enabled by the A-device |
| a_conn | input | 1 | A-device connected |
| a_bus_suspend | input | 1 | A-device suspended the bus |
| a_bus_resume | input | 1 | A-device resumed the bus |
| acon_limit | input | TMR_W | Wait-for-connect timeout in ticks |
| drv_vbus | output | 1 | VBUS drive (always off) |
| chrg_vbus | output | 1 | VBUS charge pulse |
| loc_conn | output | 1 | Local data-line pull-up connect |
| loc_sof | output | 1 | Local SOF generation |
| state_o | output | 3 | Current state code |

## Verification
The bench checks the length and order of the SRP pulses against the tick phase. A controller that counted clocks instead of ticks, or that overlapped the two windows, would show wrong pulse lengths. It also drives several exits in the same cycle: connect with resume, and session valid with a session request. A wrong priority would send the state to peripheral instead of host, or to SRP instead of peripheral. The timeout runs at a limit of zero and at a nonzero limit, which catches an off-by-one or a timer that is not cleared on entry. Each abort path (ID low in SRP, in host and in idle, and the session dropping) is checked so that the state returns straight to idle.

// File: rtl/otgb_pkg.sv
package otgb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SRP    = 3'd1,
        ST_PERIPH = 3'd2,
        ST_WAITA  = 3'd3,
        ST_HOST   = 3'd4
    } otgb_state_e;
endpackage

// File: rtl/otgb_tick_gen.sv
// Prescaler: one tick pulse every DIV clocks.
module otgb_tick_gen #(
    parameter int DIV = 2000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_gap_chk
            // R13: ticks never come back to back when the divider exceeds one
            assert_tick_gap_R13: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/otgb_srp_seq.sv
// Session request pulse sequencer: pull-up window, then charge window, then done.
module otgb_srp_seq #(
    parameter int PU_TICKS  = 1000,
    parameter int CHG_TICKS = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    output logic pu_pulse,
    output logic chg_pulse,
    output logic done
);
    localparam int TOTAL = PU_TICKS + CHG_TICKS;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam logic [CW-1:0] PU_END  = CW'(PU_TICKS);
    localparam logic [CW-1:0] ALL_END = CW'(TOTAL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active)
            cnt <= '0;
        else if (tick && cnt != ALL_END)
            cnt <= cnt + 1'b1;
    end

    assign pu_pulse  = active && (cnt < PU_END);
    assign chg_pulse = active && (cnt >= PU_END) && (cnt < ALL_END);
    assign done      = active && (cnt == ALL_END);

    // R3: the charge window only opens straight after the pull-up window
    assert_chg_follows_pu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chg_pulse) |-> $past(pu_pulse));
endmodule

// File: rtl/otgb_acon_timer.sv
// Saturating tick counter for the wait-for-connect timeout.
module otgb_acon_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         tmo
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active)
            cnt <= '0;
        else if (tick && cnt < limit)
            cnt <= cnt + 1'b1;
    end

    assign tmo = active && (cnt >= limit);

    // R7: once expired, the timeout stays up until the timer is released
    assert_tmo_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && active && $stable(limit)) |=> (tmo || !active || !$stable(limit)));
endmodule

// File: rtl/otgb_role_ctrl.sv
module otgb_role_ctrl
    import otgb_pkg::*;
#(
    parameter int TICK_DIV  = 2000,
    parameter int PU_TICKS  = 1000,
    parameter int CHG_TICKS = 3000,
    parameter int TMR_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_hi,
    input  logic             b_sess_vld,
    input  logic             b_sess_end,
    input  logic             se0_srp,
    input  logic             bus_req,
    input  logic             hnp_en,
    input  logic             a_conn,
    input  logic             a_bus_suspend,
    input  logic             a_bus_resume,
    input  logic [TMR_W-1:0] acon_limit,
    output logic             drv_vbus,
    output logic             chrg_vbus,
    output logic             loc_conn,
    output logic             loc_sof,
    output logic [2:0]       state_o
);
    otgb_state_e state, state_nx;
    logic tick, srp_pu, srp_chg, srp_done, acon_tmo;

    otgb_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    otgb_srp_seq #(.PU_TICKS(PU_TICKS), .CHG_TICKS(CHG_TICKS)) u_srp (
        .clk(clk), .rst_n(rst_n), .active(state == ST_SRP), .tick(tick),
        .pu_pulse(srp_pu), .chg_pulse(srp_chg), .done(srp_done)
    );

    otgb_acon_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .active(state == ST_WAITA), .tick(tick),
        .limit(acon_limit), .tmo(acon_tmo)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (id_hi && b_sess_vld)
                    state_nx = ST_PERIPH;
                else if (id_hi && bus_req && b_sess_end && se0_srp)
                    state_nx = ST_SRP;
            end
            ST_SRP: begin
                if (!id_hi || srp_done)
                    state_nx = ST_IDLE;
            end
            ST_PERIPH: begin
                if (!id_hi || !b_sess_vld)
                    state_nx = ST_IDLE;
                else if (bus_req && hnp_en && a_bus_suspend)
                    state_nx = ST_WAITA;
            end
            ST_WAITA: begin
                if (!id_hi || !b_sess_vld)
                    state_nx = ST_IDLE;
                else if (a_conn)
                    state_nx = ST_HOST;
                else if (a_bus_resume || acon_tmo)
                    state_nx = ST_PERIPH;
            end
            ST_HOST: begin
                if (!id_hi || !b_sess_vld)
                    state_nx = ST_IDLE;
                else if (!bus_req || !a_conn)
                    state_nx = ST_PERIPH;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Output decode
    always_comb begin
        drv_vbus  = 1'b0;
        chrg_vbus = 1'b0;
        loc_conn  = 1'b0;
        loc_sof   = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_SRP: begin
                loc_conn  = srp_pu;
                chrg_vbus = srp_chg;
            end
            ST_PERIPH: loc_conn = 1'b1;
            ST_WAITA:  ;
            ST_HOST:   loc_sof = 1'b1;
            default:   ;
        endcase
    end

    assign state_o = state;

    // R2: SRP is only entered from idle with the full request condition
    assert_srp_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SRP) |-> $past(state == ST_IDLE && id_hi && bus_req && b_sess_end && se0_srp));

    // R3: finished pulse sequence ends the SRP state
    assert_srp_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRP && srp_done) |=> state == ST_IDLE);

    // R8: host role is only reached through wait-for-connect
    assert_host_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_HOST) |-> $past(state == ST_WAITA));

    // R10: ID low in any non-idle state forces idle
    assert_id_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !id_hi) |=> state == ST_IDLE);

    // R7: timeout in wait-for-connect without connect goes back to peripheral
    assert_tmo_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAITA && acon_tmo && id_hi && b_sess_vld && !a_conn) |=> state == ST_PERIPH);
endmodule

// File: tb/test_otgb_role_ctrl.sv
module test_otgb_role_ctrl;
    localparam int DIV = 4;
    localparam int PU  = 3;
    localparam int CHG = 5;
    localparam int TW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_hi = 1'b1, b_sess_vld = 1'b0, b_sess_end = 1'b0, se0_srp = 1'b0;
    logic bus_req = 1'b0, hnp_en = 1'b0, a_conn = 1'b0;
    logic a_bus_suspend = 1'b0, a_bus_resume = 1'b0;
    logic [TW-1:0] acon_limit = 8'd5;
    logic drv_vbus, chrg_vbus, loc_conn, loc_sof;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    otgb_role_ctrl #(.TICK_DIV(DIV), .PU_TICKS(PU), .CHG_TICKS(CHG), .TMR_W(TW)) i_otgb_role_ctrl (
        .clk(clk), .rst_n(rst_n), .id_hi(id_hi), .b_sess_vld(b_sess_vld),
        .b_sess_end(b_sess_end), .se0_srp(se0_srp), .bus_req(bus_req),
        .hnp_en(hnp_en), .a_conn(a_conn), .a_bus_suspend(a_bus_suspend),
        .a_bus_resume(a_bus_resume), .acon_limit(acon_limit),
        .drv_vbus(drv_vbus), .chrg_vbus(chrg_vbus), .loc_conn(loc_conn),
        .loc_sof(loc_sof), .state_o(state_o)
    );

    // Behavioural reference model
    int m_state = 0;
    int m_phase = 0;
    int m_srp = 0;
    int m_tmr = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_phase = 0; m_srp = 0; m_tmr = 0;
        end else begin
            bit tk;
            int nxt;
            tk = (m_phase == DIV - 1);
            nxt = m_state;
            case (m_state)
                0: if (id_hi && b_sess_vld) nxt = 2;
                   else if (id_hi && bus_req && b_sess_end && se0_srp) nxt = 1;
                1: if (!id_hi || m_srp == PU + CHG) nxt = 0;
                2: if (!id_hi || !b_sess_vld) nxt = 0;
                   else if (bus_req && hnp_en && a_bus_suspend) nxt = 3;
                3: if (!id_hi || !b_sess_vld) nxt = 0;
                   else if (a_conn) nxt = 4;
                   else if (a_bus_resume || m_tmr >= int'(acon_limit)) nxt = 2;
                4: if (!id_hi || !b_sess_vld) nxt = 0;
                   else if (!bus_req || !a_conn) nxt = 2;
                default: nxt = 0;
            endcase
            if (m_state == 1) begin
                if (tk && m_srp < PU + CHG) m_srp++;
            end else m_srp = 0;
            if (m_state == 3) begin
                if (tk && m_tmr < int'(acon_limit)) m_tmr++;
            end else m_tmr = 0;
            m_phase = tk ? 0 : m_phase + 1;
            m_state = nxt;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        chk("R12 state_o", int'(state_o), m_state);
        chk("R5 R3 R13 loc_conn", int'(loc_conn),
            int'(m_state == 2 || (m_state == 1 && m_srp < PU)));
        chk("R3 R13 chrg_vbus", int'(chrg_vbus),
            int'(m_state == 1 && m_srp >= PU && m_srp < PU + CHG));
        chk("R8 loc_sof", int'(loc_sof), int'(m_state == 4));
        chk("R11 drv_vbus", int'(drv_vbus), 0);
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic to_waita();
        bus_req = 1'b1; hnp_en = 1'b1; a_bus_suspend = 1'b1;
        step(1);
        a_bus_suspend = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", int'(state_o), 0);
        chk("R1 reset outputs", int'({loc_conn, chrg_vbus, loc_sof, drv_vbus}), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1 idle after reset", int'(state_o), 0);

        // R2 / R3: full SRP sequence
        bus_req = 1'b1; b_sess_end = 1'b1; se0_srp = 1'b1;
        step(1);
        chk("R2 enter SRP", int'(state_o), 1);
        chk("R3 pull-up pulse first", int'(loc_conn), 1);
        b_sess_end = 1'b0; se0_srp = 1'b0;
        step((PU + CHG + 2) * DIV);
        chk("R3 SRP returns to idle", int'(state_o), 0);

        // R4: SRP abort on ID low
        b_sess_end = 1'b1; se0_srp = 1'b1;
        step(1);
        b_sess_end = 1'b0; se0_srp = 1'b0;
        step(2);
        id_hi = 1'b0;
        step(1);
        chk("R4 SRP abort", int'(state_o), 0);
        chk("R4 pulses end", int'({loc_conn, chrg_vbus}), 0);

        // R5: ID low blocks session-valid entry
        b_sess_vld = 1'b1;
        step(2);
        chk("R5 stay idle with ID low", int'(state_o), 0);
        id_hi = 1'b1;

        // R2 / R5: session valid beats a session request
        b_sess_end = 1'b1; se0_srp = 1'b1;
        step(1);
        chk("R2 R5 valid priority", int'(state_o), 2);
        chk("R5 pull-up in peripheral", int'(loc_conn), 1);
        b_sess_end = 1'b0; se0_srp = 1'b0;

        // R6 / R8: HNP to host, connect beats resume
        to_waita();
        chk("R6 enter wait-for-connect", int'(state_o), 3);
        chk("R6 outputs low", int'({loc_conn, chrg_vbus, loc_sof}), 0);
        a_conn = 1'b1; a_bus_resume = 1'b1;
        step(1);
        chk("R8 connect priority", int'(state_o), 4);
        chk("R8 SOF on", int'(loc_sof), 1);
        a_bus_resume = 1'b0;

        // R9: bus request drop
        bus_req = 1'b0;
        step(1);
        chk("R9 request drop", int'(state_o), 2);
        a_conn = 1'b0;

        // R7: timeout at nonzero limit
        acon_limit = 8'd5;
        to_waita();
        step(10);
        chk("R7 no early timeout", int'(state_o), 3);
        step(20);
        chk("R7 timeout to peripheral", int'(state_o), 2);

        // R7: limit of zero
        acon_limit = 8'd0;
        to_waita();
        step(1);
        chk("R7 zero limit", int'(state_o), 2);

        // R7: resume
        acon_limit = 8'd200;
        to_waita();
        step(3);
        a_bus_resume = 1'b1;
        step(1);
        chk("R7 resume", int'(state_o), 2);
        a_bus_resume = 1'b0;

        // R9: connect drop in host
        to_waita();
        a_conn = 1'b1;
        step(1);
        chk("R8 host again", int'(state_o), 4);
        a_conn = 1'b0;
        step(1);
        chk("R9 connect drop", int'(state_o), 2);

        // R10: ID low in host
        to_waita();
        a_conn = 1'b1;
        step(1);
        id_hi = 1'b0;
        step(1);
        chk("R10 ID low from host", int'(state_o), 0);
        chk("R10 outputs off", int'({loc_conn, chrg_vbus, loc_sof}), 0);
        id_hi = 1'b1; a_conn = 1'b0;
        step(1);
        chk("R5 re-enter peripheral", int'(state_o), 2);

        // R10: session drop in wait-for-connect, beats connect
        to_waita();
        b_sess_vld = 1'b0; a_conn = 1'b1;
        step(1);
        chk("R10 session drop", int'(state_o), 0);
        a_conn = 1'b0; bus_req = 1'b0; hnp_en = 1'b0;
        step(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule